// File: doc/BRIEF.md
# Windowed Watchdog Timer with Event Interrupts

This block is a 12-bit watchdog counter. Software must restart it inside a time window. It counts up on a slow tick enable, once per tick. If the count reaches a programmed period value, it reloads and flags a period-expiry event. If software restarts it too early, while the count is still below a repeat threshold, it flags a premature-restart event. A third event fires when the count steps onto a programmable level threshold. Each of the two window violations can be routed, through mode bits, to a one-cycle reset request. All three events are latched in a status register that clears when read. They are gated by a mask register, which is set and cleared through separate write-one ports, and the masked result drives a single interrupt line.

A small state machine sits at the centre of the block. It has three states. ST_OFF holds the counter at zero. ST_RUN counts ticks. ST_HALT freezes the count while a debug or idle condition is present and its halt enable is set. The transitions are:
- enable (ST_OFF to ST_RUN)
- halt (ST_RUN to ST_HALT)
- release (ST_HALT to ST_RUN)
- disable (ST_RUN or ST_HALT to ST_OFF)

Software drives the block through a simple word-addressed read/write port. Reads are combinational.

Top module: `wdg_window_timer`

## Requirements
- R1: After reset these registers read as follows: mode (0x04) reads 0x0000_1000 (disabled), window (0x0C) reads 0x0000_0FFF, level (0x10) reads 0, mask (0x20) reads 0, status (0x1C) reads 0 and counter (0x08) reads 0. irq_o and rst_req_o are low.
- R2: In ST_RUN, with no halt request, each cycle with tick_i high raises the counter by one. The counter reads at 0x08 bits 11:0. The first tick is counted one cycle after the enable transition.
- R3: A tick that arrives while the counter equals the period value (window bits 11:0) reloads the counter to 0 and sets status bit 0. If mode bit 4 is set, rst_req_o is high for exactly the next cycle.
- R4: A restart is a write to 0x00 with bits 31:24 = 0xA5 and bit 0 = 1. It clears the counter in ST_RUN or ST_HALT. If the counter was below the repeat threshold (window bits 27:16), the restart sets status bit 1, and with mode bit 5 set it pulses rst_req_o in the next cycle.
- R5: A write to 0x00 with a different key, or with bit 0 clear, has no effect on the counter or the status.
- R6: A tick increment that makes the counter equal a non-zero level threshold (0x10 bits 11:0) sets status bit 2.
- R7: Writing ones to 0x14 sets the matching mask bits, and writing ones to 0x18 clears them. The mask reads at 0x20. Only bits 2:0 exist; bits 3 and 4 always read 0.
- R8: Reading 0x1C returns the status and clears it. An event in the same cycle as the read stays set.
- R9: irq_o is high exactly when status AND mask is non-zero.
- R10: With mode bit 28 set and dbg_i high, or mode bit 29 set and idle_i high, the block is in ST_HALT and ticks are ignored. A restart still acts. A halt input whose enable bit is clear has no effect.
- R11: Mode bit 12 set puts the block in ST_OFF. There the counter is 0, no event fires, and a restart is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counting enable from the slow prescaler |
| dbg_i | input | 1 | Processor debug state |
| idle_i | input | 1 | Processor idle state |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clears status at 0x1C) |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Masked event interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that a read strobe and a write strobe never target the status register in the same cycle, and that reset is asserted before the first clock edge. The bench issues at most one bus operation per cycle, so a read and a write never overlap. It holds rst_n low from time zero for several cycles. In the pseudo-random phase, periods and thresholds are kept small so that every window event occurs many times. The tick divider and the halt inputs are changed only on the bench's own drive point after each clock edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_HALT} wdg_state_e;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_MODE = 8'h04;
    localparam logic [7:0] A_CNT  = 8'h08;
    localparam logic [7:0] A_WIN  = 8'h0C;
    localparam logic [7:0] A_LVL  = 8'h10;
    localparam logic [7:0] A_IEN  = 8'h14;
    localparam logic [7:0] A_IDIS = 8'h18;
    localparam logic [7:0] A_STAT = 8'h1C;
    localparam logic [7:0] A_MASK = 8'h20;

    localparam int B_RPER  = 4;
    localparam int B_RREP  = 5;
    localparam int B_OFF   = 12;
    localparam int B_HDBG  = 28;
    localparam int B_HIDLE = 29;

    localparam int NEV    = 3;
    localparam int EV_PER = 0;
    localparam int EV_REP = 1;
    localparam int EV_LVL = 2;

    localparam logic [7:0] KICK_KEY = 8'hA5;
endpackage

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           dbg_i,
    input  logic           idle_i,
    input  logic           off_i,
    input  logic           hdbg_en_i,
    input  logic           hidle_en_i,
    input  logic           rper_en_i,
    input  logic           rrep_en_i,
    input  logic [CW-1:0]  period_i,
    input  logic [CW-1:0]  rpth_i,
    input  logic [CW-1:0]  level_i,
    input  logic           kick_i,
    output logic [CW-1:0]  cnt_o,
    output logic [NEV-1:0] ev_o,
    output logic           rst_req_o
);
    wdg_state_e    state, nstate;
    logic [CW-1:0] cnt, cnt_nx, cnt_inc;
    logic          halt_req;

    assign halt_req = (dbg_i & hdbg_en_i) | (idle_i & hidle_en_i);
    assign cnt_inc  = cnt + 1'b1;
    assign cnt_o    = cnt;

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_OFF:  nstate = off_i ? ST_OFF : ST_RUN;
            ST_RUN:  nstate = off_i ? ST_OFF : (halt_req ? ST_HALT : ST_RUN);
            ST_HALT: nstate = off_i ? ST_OFF : (halt_req ? ST_HALT : ST_RUN);
            default: nstate = ST_OFF;
        endcase
    end

    // counter and event outputs
    always_comb begin
        ev_o   = '0;
        cnt_nx = cnt;
        if (state == ST_OFF || off_i) begin
            cnt_nx = '0;
        end else if (kick_i) begin
            cnt_nx         = '0;
            ev_o[EV_REP]   = (cnt < rpth_i);
        end else if (state == ST_RUN && !halt_req && tick_i) begin
            if (cnt == period_i) begin
                cnt_nx       = '0;
                ev_o[EV_PER] = 1'b1;
            end else begin
                cnt_nx       = cnt_inc;
                ev_o[EV_LVL] = (cnt_inc == level_i) && (level_i != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            cnt       <= '0;
            rst_req_o <= 1'b0;
        end else begin
            state     <= nstate;
            cnt       <= cnt_nx;
            rst_req_o <= (ev_o[EV_PER] & rper_en_i) | (ev_o[EV_REP] & rrep_en_i);
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> ((cnt == CW'($past(cnt) + 1'b1)) || (cnt == '0)));

    // R11
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (cnt == '0));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !kick_i && !off_i) |=> $stable(cnt));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic           rd_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [CW-1:0]  cnt_i,
    input  logic [NEV-1:0] ev_i,
    output logic [DW-1:0]  rdata_o,
    output logic           irq_o,
    output logic           kick_o,
    output logic           off_o,
    output logic           hdbg_en_o,
    output logic           hidle_en_o,
    output logic           rper_en_o,
    output logic           rrep_en_o,
    output logic [CW-1:0]  period_o,
    output logic [CW-1:0]  rpth_o,
    output logic [CW-1:0]  level_o
);
    localparam int RP_LSB = 16;

    logic [NEV-1:0] mask_q, stat_q;
    logic           wr_mode, wr_win, wr_lvl, wr_ien, wr_idis, rd_stat;

    assign wr_mode = wr_i && addr_i == AW'(A_MODE);
    assign wr_win  = wr_i && addr_i == AW'(A_WIN);
    assign wr_lvl  = wr_i && addr_i == AW'(A_LVL);
    assign wr_ien  = wr_i && addr_i == AW'(A_IEN);
    assign wr_idis = wr_i && addr_i == AW'(A_IDIS);
    assign rd_stat = rd_i && addr_i == AW'(A_STAT);
    assign kick_o  = wr_i && addr_i == AW'(A_CTRL) &&
                     wdata_i[DW-1 -: 8] == KICK_KEY && wdata_i[0];
    assign irq_o   = |(stat_q & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_o      <= 1'b1;
            hdbg_en_o  <= 1'b0;
            hidle_en_o <= 1'b0;
            rper_en_o  <= 1'b0;
            rrep_en_o  <= 1'b0;
            period_o   <= '1;
            rpth_o     <= '0;
            level_o    <= '0;
            mask_q     <= '0;
            stat_q     <= '0;
        end else begin
            if (wr_mode) begin
                off_o      <= wdata_i[B_OFF];
                hdbg_en_o  <= wdata_i[B_HDBG];
                hidle_en_o <= wdata_i[B_HIDLE];
                rper_en_o  <= wdata_i[B_RPER];
                rrep_en_o  <= wdata_i[B_RREP];
            end
            if (wr_win) begin
                period_o <= wdata_i[CW-1:0];
                rpth_o   <= wdata_i[RP_LSB +: CW];
            end
            if (wr_lvl) level_o <= wdata_i[CW-1:0];
            if (wr_ien)       mask_q <= mask_q | wdata_i[NEV-1:0];
            else if (wr_idis) mask_q <= mask_q & ~wdata_i[NEV-1:0];
            stat_q <= (rd_stat ? '0 : stat_q) | ev_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            AW'(A_MODE): begin
                rdata_o[B_OFF]   = off_o;
                rdata_o[B_HDBG]  = hdbg_en_o;
                rdata_o[B_HIDLE] = hidle_en_o;
                rdata_o[B_RPER]  = rper_en_o;
                rdata_o[B_RREP]  = rrep_en_o;
            end
            AW'(A_CNT):  rdata_o[CW-1:0] = cnt_i;
            AW'(A_WIN): begin
                rdata_o[CW-1:0]        = period_o;
                rdata_o[RP_LSB +: CW]  = rpth_o;
            end
            AW'(A_LVL):  rdata_o[CW-1:0]  = level_o;
            AW'(A_STAT): rdata_o[NEV-1:0] = stat_q;
            AW'(A_MASK): rdata_o[NEV-1:0] = mask_q;
            default:     rdata_o = '0;
        endcase
    end

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (stat_q == $past(ev_i)));

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien |=> ((mask_q & $past(wdata_i[NEV-1:0])) == $past(wdata_i[NEV-1:0])));
endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
    import wdg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          dbg_i,
    input  logic          idle_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o,
    output logic          rst_req_o
);
    logic [CW-1:0]  cnt, period, rpth, level;
    logic [NEV-1:0] ev;
    logic           kick, off, hdbg_en, hidle_en, rper_en, rrep_en;

    wdg_regs #(.CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .cnt_i(cnt), .ev_i(ev),
        .rdata_o(bus_rdata_o), .irq_o(irq_o), .kick_o(kick), .off_o(off),
        .hdbg_en_o(hdbg_en), .hidle_en_o(hidle_en), .rper_en_o(rper_en),
        .rrep_en_o(rrep_en), .period_o(period), .rpth_o(rpth), .level_o(level)
    );

    wdg_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_i(dbg_i),
        .idle_i(idle_i), .off_i(off), .hdbg_en_i(hdbg_en),
        .hidle_en_i(hidle_en), .rper_en_i(rper_en), .rrep_en_i(rrep_en),
        .period_i(period), .rpth_i(rpth), .level_i(level), .kick_i(kick),
        .cnt_o(cnt), .ev_o(ev), .rst_req_o(rst_req_o)
    );
endmodule

// File: tb/tb_wdg_window_timer.sv
module tb_wdg_window_timer;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tick = 1'b0, dbg = 1'b0, idle = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rstq;

    always #5 clk = ~clk;

    wdg_window_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_i(dbg), .idle_i(idle),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .rst_req_o(rstq)
    );

    int n_chk = 0, n_fail = 0;
    int tdiv = 1, tphase = 0;
    bit done = 0;

    // behavioural reference: 0 off, 1 run, 2 halt
    int m_st = 0, m_cnt = 0, m_per = 4095, m_rp = 0, m_lv = 0, m_mask = 0, m_stat = 0;
    bit m_off = 1, m_rper = 0, m_rrep = 0, m_hd = 0, m_hi = 0, m_rst = 0;

    function automatic int m_read(int a);
        case (a)
            4:  return (int'(m_off) << 12) | (int'(m_rper) << 4) | (int'(m_rrep) << 5) |
                       (int'(m_hd) << 28) | (int'(m_hi) << 29);
            8:  return m_cnt;
            12: return (m_rp << 16) | m_per;
            16: return m_lv;
            28: return m_stat;
            32: return m_mask;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            8:  return "R2";
            28: return "R8";
            32: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 4095; m_rp = 0; m_lv = 0; m_mask = 0; m_stat = 0;
            m_off = 1; m_rper = 0; m_rrep = 0; m_hd = 0; m_hi = 0; m_rst = 0;
        end else begin
            int  ev;
            bit  halt, kick;
            ev   = 0;
            halt = (dbg && m_hd) || (idle && m_hi);
            kick = wr && addr == 8'h00 && wdata[31:24] == 8'hA5 && wdata[0];
            if (m_st == 0 || m_off) m_cnt = 0;
            else if (kick) begin
                if (m_cnt < m_rp) ev |= 2;
                m_cnt = 0;
            end else if (m_st == 1 && !halt && tick) begin
                if (m_cnt == m_per) begin m_cnt = 0; ev |= 1; end
                else begin
                    m_cnt = (m_cnt + 1) % 4096;
                    if (m_cnt == m_lv && m_lv != 0) ev |= 4;
                end
            end
            if (m_off) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else m_st = halt ? 2 : 1;
            m_rst = ((ev & 1) != 0 && m_rper) || ((ev & 2) != 0 && m_rrep);
            if (rd && addr == 8'h1C) m_stat = 0;
            m_stat |= ev;
            if (wr) begin
                case (addr)
                    8'h04: begin
                        m_off = wdata[12]; m_rper = wdata[4]; m_rrep = wdata[5];
                        m_hd = wdata[28]; m_hi = wdata[29];
                    end
                    8'h0C: begin m_per = int'(wdata[11:0]); m_rp = int'(wdata[27:16]); end
                    8'h10: m_lv = int'(wdata[11:0]);
                    8'h14: m_mask |= int'(wdata[2:0]);
                    8'h18: m_mask &= ~int'(wdata[2:0]);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison in mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq == ((m_stat & m_mask) != 0), "R9", int'(irq), int'((m_stat & m_mask) != 0));
            check(rstq == m_rst, "R3 R4 reset request", int'(rstq), int'(m_rst));
            if (rd) check(rdata == m_read(int'(addr)), tag_of(int'(addr)), int'(rdata), m_read(int'(addr)));
        end
    end

    task automatic op(bit w, bit r, logic [7:0] a, logic [31:0] d);
        @(posedge clk); #2;
        wr = w; rd = r; addr = a; wdata = d;
        tick = (tphase == 0);
        tphase = (tphase + 1) % tdiv;
    endtask
    task automatic wrt(logic [7:0] a, logic [31:0] d); op(1, 0, a, d); endtask
    task automatic nop(int n); repeat (n) op(0, 0, 8'h00, 32'h0); endtask
    task automatic rd_exp(logic [7:0] a, int exp, string req);
        op(0, 1, a, 32'h0);
        @(negedge clk);
        check(rdata == exp, req, int'(rdata), exp);
    endtask
    task automatic rd_chk(logic [7:0] a, string req);
        op(0, 1, a, 32'h0);
        @(negedge clk);
        check(rdata == m_read(int'(a)), req, int'(rdata), m_read(int'(a)));
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        lf = 32'h1234_5678;
        nop(5);
        @(posedge clk); #2; rst_n = 1'b1;
        // R1 reset values
        rd_exp(8'h04, 32'h0000_1000, "R1");
        rd_exp(8'h0C, 32'h0000_0FFF, "R1");
        rd_exp(8'h10, 0, "R1");
        rd_exp(8'h20, 0, "R1");
        rd_exp(8'h1C, 0, "R1");
        rd_exp(8'h08, 0, "R1");
        check(irq == 0 && rstq == 0, "R1", int'({irq, rstq}), 0);
        // R11 restart ignored while disabled
        wrt(8'h00, 32'hA500_0001); nop(3);
        rd_exp(8'h1C, 0, "R11");
        rd_exp(8'h08, 0, "R11");
        // setup: period 9, repeat threshold 4, level 6
        wrt(8'h0C, 32'h0004_0009); wrt(8'h10, 32'h6); wrt(8'h14, 32'h7);
        wrt(8'h04, 32'h0000_0010);
        nop(2); rd_chk(8'h08, "R2");
        nop(20); rd_chk(8'h1C, "R3");
        rd_chk(8'h1C, "R8");
        rd_chk(8'h20, "R7");
        // R4 premature and in-window restarts
        wrt(8'h04, 32'h0000_0030); wrt(8'h00, 32'hA500_0001); nop(1);
        rd_chk(8'h1C, "R4");
        nop(6); wrt(8'h00, 32'hA500_0001);
        rd_chk(8'h1C, "R4");
        // R5 bad key / missing bit
        wrt(8'h00, 32'h5A00_0001); rd_chk(8'h08, "R5");
        wrt(8'h00, 32'hA500_0000); rd_chk(8'h08, "R5");
        // R6 level event
        nop(8); rd_chk(8'h1C, "R6");
        // R7 mask clear, non-existent bits
        wrt(8'h18, 32'h3); rd_chk(8'h20, "R7");
        wrt(8'h14, 32'h18); rd_exp(8'h20, 4, "R7");
        nop(15);
        // R10 halt behaviour
        wrt(8'h04, 32'h1000_0030); dbg = 1'b1;
        nop(5); rd_chk(8'h08, "R10"); nop(5); rd_chk(8'h08, "R10");
        wrt(8'h00, 32'hA500_0001); rd_chk(8'h08, "R10");
        dbg = 1'b0; idle = 1'b1;
        nop(3); rd_chk(8'h08, "R10");
        wrt(8'h04, 32'h2000_0030); nop(4); rd_chk(8'h08, "R10");
        idle = 1'b0;
        // R11 disable
        wrt(8'h04, 32'h0000_1030); nop(3); rd_chk(8'h08, "R11");
        rd_chk(8'h1C, "R11");
        // pseudo-random phase
        tdiv = 3;
        for (int i = 0; i < 3000; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            case (lf % 16)
                0: wrt(8'h00, 32'hA500_0001);
                1: wrt(8'h00, {lf[31:24] ^ 8'h01, 23'h0, lf[0]});
                2: wrt(8'h0C, {12'h0, 4'(lf[11:8]), 4'h0, 12'((lf >> 12) % 24)});
                3: wrt(8'h10, 32'((lf >> 8) % 24));
                4: wrt(8'h14, {27'h0, lf[12:8]});
                5: wrt(8'h18, {27'h0, lf[12:8]});
                6: wrt(8'h04, {2'b0, lf[29:28], 15'h0, (lf[10:8] == 3'b0), 6'h0, lf[5:4], 4'h0});
                7: begin dbg = lf[8]; nop(1); end
                8: begin idle = lf[9]; nop(1); end
                9, 10, 11: begin
                    logic [7:0] ra;
                    case (lf[10:8])
                        3'd0: ra = 8'h04; 3'd1: ra = 8'h0C; 3'd2: ra = 8'h10;
                        3'd3: ra = 8'h20; 3'd4, 3'd5: ra = 8'h1C;
                        default: ra = 8'h08;
                    endcase
                    op(0, 1, ra, 32'h0);
                end
                default: nop(1);
            endcase
        end
        nop(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule